// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This block samples a 32-bit bank of asynchronous digital inputs and raises a level interrupt when a programmable condition is met on channels 4 through 19. Two condition masks qualify the channels. The first selects channels that react to a rising edge or, in level mode, to a high level. The second selects channels that react to a falling edge or, in level mode, to a low level. A control word turns the interrupt on and picks how the per-channel conditions are combined. In edge mode any qualified edge is enough. In level mode every selected channel must hold its level in the same cycle.

Software reads the raw synchronized inputs and a latched snapshot of channels 19..4 taken when the event fired. It also programs the masks and the control word over a simple 32-bit register bus. Reading the snapshot clears it. The interrupt line stays high until software clears the enable bit, and software then writes the enable bit back to re-arm. In level mode a selected input must change after a firing before the logic can fire again, so a condition that stays true does not raise the interrupt repeatedly.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset, irq is 0 and the status word (offset 0x0C), control word (offset 0x10) and first mask (offset 0x04) all read 0.
- R2: The mask words at offsets 0x04 (rising/high) and 0x08 (falling/low) store only bits 19..4 of the written data. All other bits read back as 0.
- R3: The control word at offset 0x10 holds the enable in bit 2 and the combine mode in bit 1 (1 = level/AND, 0 = edge/OR). All other bits read back as 0.
- R4: Offset 0x00 returns all 32 input bits as sampled through a two-flop synchronizer. A new input value is visible within three clocks.
- R5: In edge mode with the enable set, a rising edge on a channel set in the first mask, or a falling edge on a channel set in the second mask, sets irq. Edges on unselected channels, on channels outside 19..4, or of the unselected polarity have no effect.
- R6: In edge mode, a channel set in both masks raises irq on either edge.
- R7: In level mode with the enable set, irq is set only when every channel in the first mask is high and every channel in the second mask is low in the same cycle.
- R8: In level mode, after a firing the logic stays disarmed while the condition holds, even across an acknowledge. Changes on unselected channels do not re-arm it. A change on a selected channel re-arms it, and the next time the condition is met it fires again.
- R9: On an event, the status word captures the synchronized state of channels 19..4, with other bits 0. A read of the status word returns that value and clears it to 0.
- R10: irq stays at 1 while the enable remains set, including across status reads. One clock after the enable is cleared, irq is 0. Writing the enable back does not re-raise irq without a new event.
- R11: When an event and a status read fall in the same clock, the read returns the previous status and the new capture is kept for the next read.
- R12: With the enable clear, qualified edges neither raise irq nor change the status word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | DATA_W | Asynchronous digital inputs |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the clock after bus_rd |
| irq | output | 1 | Interrupt request level |

## Verification
The two functions that can meet in one clock are the capture of a new event into the status word and a software read that clears that word. The bench produces this collision by changing a qualified input exactly two clocks before it issues the status read. That is the latency of the synchronizer, so the read strobe and the detected edge reach the status register on the same edge. The read is judged correct if it returns the earlier cleared value, and a following read returns the snapshot of the new event, which shows that the capture won over the clear.

// File: rtl/cos_pkg.sv
package cos_pkg;

  // Word indices of the register map (byte offset / 4)
  localparam int unsigned IDX_RAW    = 0;
  localparam int unsigned IDX_MASK_H = 1;
  localparam int unsigned IDX_MASK_L = 2;
  localparam int unsigned IDX_STATUS = 3;
  localparam int unsigned IDX_CTRL   = 4;

  // Control word bit positions
  localparam int unsigned CTRL_EN_BIT  = 2;
  localparam int unsigned CTRL_AND_BIT = 1;

  typedef enum logic {
    COMB_OR  = 1'b0,
    COMB_AND = 1'b1
  } comb_mode_e;

endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/cos_detect.sv
module cos_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] mask_h,
  input  logic [W-1:0] mask_l,
  input  logic         en,
  input  cos_pkg::comb_mode_e mode,
  input  logic         cfg_wr,
  output logic         fire
);
  import cos_pkg::*;

  logic [W-1:0] prev;
  logic [W-1:0] rise, fall, sel;
  logic         or_hit, lvl_ok, sel_changed, armed, and_hit;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= smp;
  end

  assign rise = smp & ~prev;
  assign fall = ~smp & prev;
  assign sel  = mask_h | mask_l;

  assign or_hit      = |((rise & mask_h) | (fall & mask_l));
  assign lvl_ok      = (sel != '0) && ((smp & mask_h) == mask_h) &&
                       ((~smp & mask_l) == mask_l);
  assign sel_changed = |((smp ^ prev) & sel);
  assign and_hit     = armed && lvl_ok;

  always_comb begin
    fire = 1'b0;
    if (en) begin
      if (mode == COMB_AND) fire = and_hit;
      else                  fire = or_hit;
    end
  end

  // Level-mode re-arm: disarm on firing, re-arm on a selected input change
  always_ff @(posedge clk) begin
    if (rst)                              armed <= 1'b1;
    else if (cfg_wr)                      armed <= 1'b1;
    else if (fire && (mode == COMB_AND))  armed <= 1'b0;
    else if (sel_changed)                 armed <= 1'b1;
  end

  AST_AND_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (fire && (mode == COMB_AND) && !cfg_wr) |=> !(fire && (mode == COMB_AND))); // R8

endmodule

// File: rtl/cos_regs.sv
module cos_regs #(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CH_LO  = 4,
  parameter int unsigned CH_HI  = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      smp,
  input  logic              fire,
  output logic [W-1:0]      mask_h,
  output logic [W-1:0]      mask_l,
  output logic              en,
  output cos_pkg::comb_mode_e mode,
  output logic              cfg_wr,
  output logic              irq
);
  import cos_pkg::*;

  localparam int unsigned WORD_W = ADDR_W - 2;

  function automatic logic [W-1:0] range_mask();
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (i >= CH_LO) && (i <= CH_HI);
    return m;
  endfunction

  localparam logic [W-1:0] RANGE = range_mask();

  logic [WORD_W-1:0] word;
  logic              sel_raw, sel_mh, sel_ml, sel_st, sel_ctl;
  logic              rd_status;
  logic [W-1:0]      status_q;
  logic [W-1:0]      ctrl_view;

  assign word    = bus_addr[ADDR_W-1:2];
  assign sel_raw = (word == WORD_W'(IDX_RAW));
  assign sel_mh  = (word == WORD_W'(IDX_MASK_H));
  assign sel_ml  = (word == WORD_W'(IDX_MASK_L));
  assign sel_st  = (word == WORD_W'(IDX_STATUS));
  assign sel_ctl = (word == WORD_W'(IDX_CTRL));

  assign cfg_wr    = bus_wr && (sel_mh || sel_ml);
  assign rd_status = bus_rd && sel_st;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_h <= '0;
      mask_l <= '0;
      en     <= 1'b0;
      mode   <= COMB_OR;
    end else if (bus_wr) begin
      if (sel_mh)  mask_h <= bus_wdata & RANGE;
      if (sel_ml)  mask_l <= bus_wdata & RANGE;
      if (sel_ctl) begin
        en   <= bus_wdata[CTRL_EN_BIT];
        mode <= comb_mode_e'(bus_wdata[CTRL_AND_BIT]);
      end
    end
  end

  // Event capture has priority over read-clear
  always_ff @(posedge clk) begin
    if (rst)            status_q <= '0;
    else if (fire)      status_q <= smp & RANGE;
    else if (rd_status) status_q <= '0;
  end

  // Interrupt level: set by an event, dropped while enable is low
  always_ff @(posedge clk) begin
    if (rst)      irq <= 1'b0;
    else if (!en) irq <= 1'b0;
    else if (fire) irq <= 1'b1;
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTRL_EN_BIT]  = en;
    ctrl_view[CTRL_AND_BIT] = (mode == COMB_AND);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      if (sel_raw) bus_rdata <= smp;
      if (sel_mh)  bus_rdata <= mask_h;
      if (sel_ml)  bus_rdata <= mask_l;
      if (sel_st)  bus_rdata <= status_q;
      if (sel_ctl) bus_rdata <= ctrl_view;
    end
  end

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (irq && en) |=> irq); // R10
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq); // R10
  AST_NO_FIRE_DISABLED: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(en)); // R12
  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (rd_status && !fire) |=> (status_q == '0)); // R9

endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CH_LO       = 4,
  parameter int unsigned CH_HI       = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import cos_pkg::*;

  logic [DATA_W-1:0] smp, mask_h, mask_l;
  logic              en, cfg_wr, fire;
  comb_mode_e        mode;

  cos_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(din), .q(smp)
  );

  cos_detect #(.W(DATA_W)) u_detect (
    .clk(clk), .rst(rst), .smp(smp), .mask_h(mask_h), .mask_l(mask_l),
    .en(en), .mode(mode), .cfg_wr(cfg_wr), .fire(fire)
  );

  cos_regs #(.W(DATA_W), .ADDR_W(ADDR_W), .CH_LO(CH_LO), .CH_HI(CH_HI)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .smp(smp), .fire(fire), .mask_h(mask_h), .mask_l(mask_l),
    .en(en), .mode(mode), .cfg_wr(cfg_wr), .irq(irq)
  );

endmodule

// File: tb/tb_cos_irq_ctrl.sv
module tb_cos_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] din = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  logic        rd_q = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  cos_irq_ctrl dut (
    .clk(clk), .rst(rst), .din(din), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam logic [4:0] A_RAW = 5'h00, A_MH = 5'h04, A_ML = 5'h08,
                         A_ST = 5'h0C, A_CTL = 5'h10;

  always @(posedge clk) rd_q <= bus_rd;

  // Monitor: pops the expected read data when the read result appears
  always @(negedge clk) begin
    if (rd_q) begin
      logic [31:0] e;
      string t;
      if (exp_q.size() == 0) begin
        e = '0; t = "unexpected read";
      end else begin
        e = exp_q.pop_front(); t = tag_q.pop_front();
      end
      checks++;
      if (bus_rdata !== e) begin
        fails++;
        $display("FAIL %s: rdata actual=%h expected=%h", t, bus_rdata, e);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  task automatic ack(input logic [31:0] ctl);
    wr(A_CTL, 32'h0);
    wr(A_CTL, ctl);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd(A_ST, 32'h0, "R1 status after reset");
    rd(A_CTL, 32'h0, "R1 ctrl after reset");
    rd(A_MH, 32'h0, "R1 mask after reset");

    // R2 mask range
    wr(A_MH, 32'hFFFF_FFFF);
    rd(A_MH, 32'h000F_FFF0, "R2 mask_h range");
    wr(A_ML, 32'h1234_5678);
    rd(A_ML, 32'h0004_5670, "R2 mask_l range");
    wr(A_MH, 32'h0); wr(A_ML, 32'h0);

    // R3 control bits
    wr(A_CTL, 32'hFFFF_FFFF);
    rd(A_CTL, 32'h0000_0006, "R3 ctrl bits");
    wr(A_CTL, 32'h0);

    // R4 raw input
    din = 32'hA5A5_0F0F;
    step(3);
    rd(A_RAW, 32'hA5A5_0F0F, "R4 raw read");

    // R5 edge mode
    din = 32'h0; step(4);
    wr(A_MH, 32'h0000_0010);
    wr(A_ML, 32'h0000_0020);
    wr(A_CTL, 32'h4);
    step(2);
    chk_irq(1'b0, "R5 idle");
    din = 32'h0010_0048; step(4);
    chk_irq(1'b0, "R5 unselected/out of range edges");
    rd(A_ST, 32'h0, "R5 no capture on ignored edges");
    din = 32'h0010_0058; step(4);
    chk_irq(1'b1, "R5 rising on mask_h channel");
    rd(A_ST, 32'h0000_0050, "R9 captured state");
    rd(A_ST, 32'h0, "R9 cleared by read");
    step(5);
    chk_irq(1'b1, "R10 irq held across status read");
    wr(A_CTL, 32'h0);
    step(1);
    chk_irq(1'b0, "R10 irq dropped after enable cleared");
    wr(A_CTL, 32'h4);
    step(3);
    chk_irq(1'b0, "R10 no refire on re-enable");
    din = 32'h0010_0078; step(4);
    chk_irq(1'b0, "R5 rising on mask_l channel ignored");
    din = 32'h0010_0058; step(4);
    chk_irq(1'b1, "R5 falling on mask_l channel");
    rd(A_ST, 32'h0000_0050, "R9 capture on falling edge");
    ack(32'h4);

    // R6 both masks
    wr(A_MH, 32'h0000_0080);
    wr(A_ML, 32'h0000_0080);
    step(2);
    chk_irq(1'b0, "R6 idle");
    din = 32'h0010_00D8; step(4);
    chk_irq(1'b1, "R6 rising with both masks");
    ack(32'h4);
    din = 32'h0010_0058; step(4);
    chk_irq(1'b1, "R6 falling with both masks");
    rd(A_ST, 32'h0000_0050, "R9 latest capture kept");
    ack(32'h0);

    // R12 disabled
    din = 32'h0010_00D8; step(4);
    chk_irq(1'b0, "R12 no irq while disabled");
    rd(A_ST, 32'h0, "R12 no capture while disabled");

    // R7 / R8 level mode
    wr(A_MH, 32'h0000_0300);
    wr(A_ML, 32'h0000_0400);
    din = 32'h0010_01D8; step(4);
    wr(A_CTL, 32'h6);
    step(4);
    chk_irq(1'b0, "R7 partial condition");
    din = 32'h0010_03D8; step(4);
    chk_irq(1'b1, "R7 all levels met");
    rd(A_ST, 32'h0000_03D0, "R9 level capture");
    ack(32'h6);
    step(4);
    chk_irq(1'b0, "R8 no refire while condition holds");
    din = 32'h0010_0BD8; step(4);
    chk_irq(1'b0, "R8 unselected change does not re-arm");
    din = 32'h0010_09D8; step(4);
    chk_irq(1'b0, "R8 condition broken");
    din = 32'h0010_0BD8; step(4);
    chk_irq(1'b1, "R8 refire after selected change");
    rd(A_ST, 32'h0000_0BD0, "R9 second level capture");
    ack(32'h4);

    // R11 capture and read-clear in the same clock
    wr(A_MH, 32'h0000_1000);
    wr(A_ML, 32'h0);
    step(2);
    rd(A_ST, 32'h0, "R11 status clear before collision");
    din = 32'h0010_1BD8;
    step(2);
    exp_q.push_back(32'h0); tag_q.push_back("R11 read in capture cycle");
    bus_addr = A_ST; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
    chk_irq(1'b1, "R11 irq on collision event");
    rd(A_ST, 32'h0000_1BD0, "R11 capture survived read");

    step(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule